// File: doc/BRIEF.md
# Hopfield Recall Network on a One-Bit State Ring

This block is a small, fully connected Hopfield network built from N identical neuron processors. Each processor keeps the N synaptic weights of its own row and one state bit. To update the network, the state bits are copied into a one-bit-wide circular shift ring of N stages. On every shift cycle each processor reads the ring bit in front of it and adds or subtracts the matching weight to its running sum, so all processors accumulate in parallel. After N shifts every processor has seen every state. Each one then compares its sum with zero and latches its new state bit, and all neurons do this in the same cycle.

A run command repeats such update rounds until a round leaves every state unchanged, which raises a done flag. A round limit stops networks that oscillate. A learn command uses the same ring to apply one outer-product step to the stored weights: each off-diagonal weight moves up by one when its two neurons agree and down by one when they differ, saturating at the weight range. Weights and patterns are loaded through simple write ports while the block is idle. The current states are always visible on a parallel output.

The controller is a six-state machine. IDLE accepts loads and commands. RUN_PREP copies the states into the ring and clears the sums. RUN_SHIFT lasts N cycles of accumulation. RUN_COMMIT latches the thresholded states and then returns to IDLE (stable, or limit reached) or goes back to RUN_PREP for another round. LRN_PREP loads the ring for learning, and LRN_SHIFT lasts N cycles of weight adjustment before it returns to IDLE.

Top module: `hopfield_ring`

## Requirements
- R1: After reset all state bits are 0, busy is 0, done is 0 and every weight is 0.
- R2: While idle, a cycle with wt_we high writes wt_data (two's complement) as weight w[wt_row][wt_col]: the weight neuron wt_row applies to the state of neuron wt_col. Writes while busy are ignored.
- R3: While idle, a cycle with pat_we high sets the state vector to pat_data (bit i is neuron i) and clears done. Pattern writes while busy are ignored.
- R4: In one update round every neuron i computes the sum over all j (including j = i) of +w[i][j] if state j is 1 and -w[i][j] if state j is 0, using the states from before the round. All neurons then take the new state 1 if the sum is at least zero and 0 otherwise, simultaneously.
- R5: busy is 1 in the cycle after run is sampled while idle, and each update round occupies exactly N+2 cycles (one prepare, N shifts, one commit).
- R6: Rounds repeat until a round produces no state change. The block then goes idle with done = 1, and done stays 1 until the next run, learn or pattern write.
- R7: If MAX_ROUNDS rounds all change the state, the block goes idle after the last of them with done = 0 and the state of that last round.
- R8: A learn command takes N+1 busy cycles. For every i different from j it changes w[i][j] by +1 if states i and j are equal and by -1 otherwise, saturating at -2^(WW-1) and 2^(WW-1)-1. It leaves w[i][i] and the states unchanged.
- R9: When run and learn are both high in the same idle cycle, only the run is performed.
- R10: run and learn pulses while busy are ignored and do not lengthen the operation.
- R11: Update rounds never modify the weights.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wt_we | input | 1 | Weight write strobe (idle only) |
| wt_row | input | $clog2(N) | Destination neuron of the weight |
| wt_col | input | $clog2(N) | Source neuron whose state the weight scales |
| wt_data | input | WW | Signed weight value |
| pat_we | input | 1 | Pattern write strobe (idle only) |
| pat_data | input | N | New state vector |
| run | input | 1 | Start recall rounds |
| learn | input | 1 | Start one outer-product learning step |
| state | output | N | Current neuron states |
| busy | output | 1 | Controller not in IDLE |
| done | output | 1 | Last recall ended on a stable state |

## Verification
Each check is placed at the cycle where its result is due. busy is checked one cycle after a command. The state vector and done are checked in the first cycle after busy falls, which happens rounds x (N+2) cycles after a run and N+1 cycles after a learn. The bench counts busy cycles and compares that count with the value its reference model derives from the number of rounds it predicts. Inputs are driven and outputs sampled on the falling clock edge, so every sample sees values settled from the preceding rising edge. Ignored stimulus is applied in the middle of a busy period, and its absence of effect shows in the final state, in the busy length and in a following recall.

// File: rtl/hrn_pkg.sv
package hrn_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RUN_PREP,
        ST_RUN_SHIFT,
        ST_RUN_COMMIT,
        ST_LRN_PREP,
        ST_LRN_SHIFT
    } hrn_state_e;
endpackage

// File: rtl/hrn_ctrl.sv
module hrn_ctrl
    import hrn_pkg::*;
#(
    parameter int N          = 8,
    parameter int MAX_ROUNDS = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   run,
    input  logic                   learn,
    input  logic                   pat_load,
    input  logic                   any_change,
    output logic                   idle,
    output logic                   done,
    output logic                   ring_load,
    output logic                   ring_shift,
    output logic                   acc_clr,
    output logic                   acc_en,
    output logic                   lrn_en,
    output logic                   commit,
    output logic [$clog2(N)-1:0]   step
);
    localparam int IW = $clog2(N);
    localparam int RW = $clog2(MAX_ROUNDS + 1);

    hrn_state_e     fsm_q, fsm_d;
    logic [RW-1:0]  rnd_q;
    logic           last_step;
    logic           limit_hit;

    assign last_step = (step == IW'(N - 1));
    assign limit_hit = (rnd_q == RW'(MAX_ROUNDS - 1));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fsm_q <= ST_IDLE;
        else        fsm_q <= fsm_d;
    end

    // next state
    always_comb begin
        fsm_d = fsm_q;
        unique case (fsm_q)
            ST_IDLE: begin
                if (run)        fsm_d = ST_RUN_PREP;
                else if (learn) fsm_d = ST_LRN_PREP;
            end
            ST_RUN_PREP:  fsm_d = ST_RUN_SHIFT;
            ST_RUN_SHIFT: if (last_step) fsm_d = ST_RUN_COMMIT;
            ST_RUN_COMMIT: begin
                if (!any_change || limit_hit) fsm_d = ST_IDLE;
                else                          fsm_d = ST_RUN_PREP;
            end
            ST_LRN_PREP:  fsm_d = ST_LRN_SHIFT;
            ST_LRN_SHIFT: if (last_step) fsm_d = ST_IDLE;
            default:      fsm_d = ST_IDLE;
        endcase
    end

    // outputs decoded from the state
    always_comb begin
        idle      = 1'b0;
        ring_load = 1'b0;
        acc_clr   = 1'b0;
        acc_en    = 1'b0;
        lrn_en    = 1'b0;
        commit    = 1'b0;
        unique case (fsm_q)
            ST_IDLE:       idle = 1'b1;
            ST_RUN_PREP: begin
                ring_load = 1'b1;
                acc_clr   = 1'b1;
            end
            ST_RUN_SHIFT:  acc_en    = 1'b1;
            ST_RUN_COMMIT: commit    = 1'b1;
            ST_LRN_PREP:   ring_load = 1'b1;
            ST_LRN_SHIFT:  lrn_en    = 1'b1;
            default:       idle      = 1'b1;
        endcase
        ring_shift = acc_en | lrn_en;
    end

    // step, round and done bookkeeping
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            step  <= '0;
            rnd_q <= '0;
            done  <= 1'b0;
        end else begin
            if (ring_load)       step <= '0;
            else if (ring_shift) step <= step + 1'b1;

            if (idle && run)  rnd_q <= '0;
            else if (commit)  rnd_q <= rnd_q + 1'b1;

            if (idle && (run || learn || pat_load)) done <= 1'b0;
            else if (commit && !any_change)         done <= 1'b1;
        end
    end

    AST_START_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        (idle && (run || learn)) |=> !idle); // R5
    AST_DONE_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> idle); // R6
    AST_COMMIT_AFTER_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> $past(acc_en)); // R5
    AST_BUSY_IGNORES_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        (lrn_en && !last_step && (run || learn)) |=> lrn_en); // R10
endmodule

// File: rtl/hrn_ring.sv
module hrn_ring #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [N-1:0] load_vec,
    input  logic         shift,
    output logic [N-1:0] bits
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      bits <= '0;
        else if (load)   bits <= load_vec;
        else if (shift)  bits <= {bits[0], bits[N-1:1]};
    end

    AST_RING_CONSERVES: assert property (@(posedge clk) disable iff (!rst_n)
        (shift && !load) |=> ($countones(bits) == $countones($past(bits)))); // R4
endmodule

// File: rtl/hrn_neuron.sv
module hrn_neuron #(
    parameter int N  = 8,
    parameter int WW = 6,
    parameter int ID = 0
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [$clog2(N)-1:0] wr_col,
    input  logic [WW-1:0]        wr_data,
    input  logic [$clog2(N)-1:0] step,
    input  logic                 ring_bit,
    input  logic                 acc_clr,
    input  logic                 acc_en,
    input  logic                 lrn_en,
    input  logic                 commit,
    input  logic                 pat_we,
    input  logic                 pat_bit,
    output logic                 state_q,
    output logic                 next_bit
);
    localparam int IW = $clog2(N);
    localparam int SW = WW + $clog2(N) + 1;
    localparam logic [WW-1:0] WMAX = {1'b0, {(WW-1){1'b1}}};
    localparam logic [WW-1:0] WMIN = {1'b1, {(WW-1){1'b0}}};

    logic [N-1:0][WW-1:0] wmem;
    logic signed [SW-1:0] acc;
    logic [IW-1:0]        col;
    logic [WW-1:0]        wsel;
    logic signed [SW-1:0] wext;
    logic                 agree;
    logic                 is_diag;

    // source neuron currently in front of this processor
    always_comb begin
        int t;
        t = ID + int'(step);
        if (t >= N) t = t - N;
        col = IW'(t);
    end

    assign wsel     = wmem[col];
    assign wext     = {{(SW-WW){wsel[WW-1]}}, wsel};
    assign agree    = (ring_bit == state_q);
    assign is_diag  = (int'(col) == ID);
    assign next_bit = ~acc[SW-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wmem <= '0;
        end else if (wr_en) begin
            wmem[wr_col] <= wr_data;
        end else if (lrn_en && !is_diag) begin
            if (agree && wsel != WMAX)       wmem[col] <= wsel + 1'b1;
            else if (!agree && wsel != WMIN) wmem[col] <= wsel - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       acc <= '0;
        else if (acc_clr) acc <= '0;
        else if (acc_en)  acc <= ring_bit ? (acc + wext) : (acc - wext);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      state_q <= 1'b0;
        else if (pat_we) state_q <= pat_bit;
        else if (commit) state_q <= next_bit;
    end

    AST_RECALL_KEEPS_WEIGHTS: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_en && !wr_en) |=> $stable(wmem)); // R11
    AST_DIAG_UNTOUCHED: assert property (@(posedge clk) disable iff (!rst_n)
        (lrn_en && is_diag && !wr_en) |=> $stable(wmem)); // R8
    AST_STATE_FIXED_IN_LEARN: assert property (@(posedge clk) disable iff (!rst_n)
        (lrn_en && !pat_we) |=> $stable(state_q)); // R8
endmodule

// File: rtl/hopfield_ring.sv
module hopfield_ring
    import hrn_pkg::*;
#(
    parameter int N          = 8,
    parameter int WW         = 6,
    parameter int MAX_ROUNDS = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wt_we,
    input  logic [$clog2(N)-1:0] wt_row,
    input  logic [$clog2(N)-1:0] wt_col,
    input  logic [WW-1:0]        wt_data,
    input  logic                 pat_we,
    input  logic [N-1:0]         pat_data,
    input  logic                 run,
    input  logic                 learn,
    output logic [N-1:0]         state,
    output logic                 busy,
    output logic                 done
);
    localparam int IW = $clog2(N);

    logic          idle, ring_load, ring_shift, acc_clr, acc_en, lrn_en, commit;
    logic [IW-1:0] step;
    logic [N-1:0]  ring_bits;
    logic [N-1:0]  state_vec;
    logic [N-1:0]  next_vec;
    logic          pat_load;
    logic          any_change;

    assign pat_load   = idle & pat_we;
    assign any_change = |(next_vec ^ state_vec);
    assign state      = state_vec;
    assign busy       = ~idle;

    hrn_ctrl #(.N(N), .MAX_ROUNDS(MAX_ROUNDS)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (run),
        .learn      (learn),
        .pat_load   (pat_load),
        .any_change (any_change),
        .idle       (idle),
        .done       (done),
        .ring_load  (ring_load),
        .ring_shift (ring_shift),
        .acc_clr    (acc_clr),
        .acc_en     (acc_en),
        .lrn_en     (lrn_en),
        .commit     (commit),
        .step       (step)
    );

    hrn_ring #(.N(N)) u_ring (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (ring_load),
        .load_vec (state_vec),
        .shift    (ring_shift),
        .bits     (ring_bits)
    );

    for (genvar g = 0; g < N; g++) begin : g_neuron
        logic wr_hit;
        assign wr_hit = idle & wt_we & (wt_row == IW'(g));

        hrn_neuron #(.N(N), .WW(WW), .ID(g)) u_neuron (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_en    (wr_hit),
            .wr_col   (wt_col),
            .wr_data  (wt_data),
            .step     (step),
            .ring_bit (ring_bits[g]),
            .acc_clr  (acc_clr),
            .acc_en   (acc_en),
            .lrn_en   (lrn_en),
            .commit   (commit),
            .pat_we   (pat_load),
            .pat_bit  (pat_data[g]),
            .state_q  (state_vec[g]),
            .next_bit (next_vec[g])
        );
    end

    AST_STATE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!commit && !pat_load) |=> $stable(state_vec)); // R3
    AST_BUSY_NO_PATTERN: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && pat_we && !commit) |=> $stable(state_vec)); // R10
endmodule

// File: tb/sim_hopfield_ring.sv
`timescale 1ns/1ps
module sim_hopfield_ring;
    localparam int N    = 8;
    localparam int WW   = 6;
    localparam int MAXR = 16;
    localparam int IW   = $clog2(N);
    localparam int WHI  = (1 << (WW - 1)) - 1;
    localparam int WLO  = -(1 << (WW - 1));

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wt_we = 1'b0;
    logic [IW-1:0] wt_row = '0;
    logic [IW-1:0] wt_col = '0;
    logic [WW-1:0] wt_data = '0;
    logic          pat_we = 1'b0;
    logic [N-1:0]  pat_data = '0;
    logic          run = 1'b0;
    logic          learn = 1'b0;
    logic [N-1:0]  state;
    logic          busy;
    logic          done;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 1'b0;

    int       mw [N][N];
    bit [N-1:0] ms;

    always #10 clk = ~clk; // 50 MHz

    hopfield_ring #(.N(N), .WW(WW), .MAX_ROUNDS(MAXR)) u0 (
        .clk(clk), .rst_n(rst_n), .wt_we(wt_we), .wt_row(wt_row), .wt_col(wt_col),
        .wt_data(wt_data), .pat_we(pat_we), .pat_data(pat_data), .run(run),
        .learn(learn), .state(state), .busy(busy), .done(done)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // reference model of one synchronous round
    function automatic bit [N-1:0] model_round(input bit [N-1:0] s);
        bit [N-1:0] nx;
        for (int i = 0; i < N; i++) begin
            int sum = 0;
            for (int j = 0; j < N; j++) sum += s[j] ? mw[i][j] : -mw[i][j];
            nx[i] = (sum >= 0);
        end
        return nx;
    endfunction

    task automatic model_run(output int rounds, output bit ok);
        bit [N-1:0] nx;
        rounds = 0;
        ok = 1'b0;
        forever begin
            nx = model_round(ms);
            rounds++;
            if (nx == ms) begin ok = 1'b1; break; end
            ms = nx;
            if (rounds == MAXR) break;
        end
    endtask

    task automatic model_learn();
        for (int i = 0; i < N; i++)
            for (int j = 0; j < N; j++)
                if (i != j) begin
                    int v = mw[i][j] + ((ms[i] == ms[j]) ? 1 : -1);
                    if (v > WHI) v = WHI;
                    if (v < WLO) v = WLO;
                    mw[i][j] = v;
                end
    endtask

    task automatic write_w(input int r, input int c, input int v);
        @(negedge clk);
        wt_we = 1'b1; wt_row = IW'(r); wt_col = IW'(c); wt_data = WW'(v);
        @(negedge clk);
        wt_we = 1'b0;
        mw[r][c] = v;
    endtask

    task automatic write_pat(input bit [N-1:0] p);
        @(negedge clk);
        pat_we = 1'b1; pat_data = p;
        @(negedge clk);
        pat_we = 1'b0;
        ms = p;
    endtask

    task automatic load_random_weights(input int span);
        for (int i = 0; i < N; i++)
            for (int j = i; j < N; j++) begin
                int v = (i == j) ? 0 : int'($urandom_range(2 * span)) - span;
                write_w(i, j, v);
                if (i != j) write_w(j, i, v);
            end
    endtask

    // issues a run (optionally with learn, optionally disturbed while busy)
    task automatic do_run(input string req, input bit with_learn, input bit disturb);
        int rounds;
        bit ok;
        int cnt;
        model_run(rounds, ok);
        @(negedge clk);
        run = 1'b1; learn = with_learn;
        @(negedge clk);
        run = 1'b0; learn = 1'b0;
        chk({req, " R5 busy after run"}, int'(busy), 1);
        cnt = 0;
        while (busy && cnt < 2000) begin
            cnt++;
            if (disturb && cnt == 2) begin
                pat_we = 1'b1; pat_data = ~ms;
                wt_we = 1'b1; wt_row = 0; wt_col = 1; wt_data = WW'(WLO);
                run = 1'b1; learn = 1'b1;
            end
            @(negedge clk);
            pat_we = 1'b0; wt_we = 1'b0; run = 1'b0; learn = 1'b0;
        end
        chk({req, " R5 busy cycles"}, cnt, rounds * (N + 2));
        chk({req, " R4 state"}, int'(state), int'(ms));
        chk({req, " R6/R7 done"}, int'(done), int'(ok));
    endtask

    task automatic do_learn(input string req);
        int cnt;
        model_learn();
        @(negedge clk);
        learn = 1'b1;
        @(negedge clk);
        learn = 1'b0;
        cnt = 0;
        while (busy && cnt < 2000) begin cnt++; @(negedge clk); end
        chk({req, " R8 learn cycles"}, cnt, N + 1);
        chk({req, " R8 state kept"}, int'(state), int'(ms));
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin : main
        void'($urandom(32'h1d5e_a7c3));
        for (int i = 0; i < N; i++) for (int j = 0; j < N; j++) mw[i][j] = 0;
        ms = '0;
        repeat (3) @(negedge clk);
        chk("R1 state", int'(state), 0);
        chk("R1 busy", int'(busy), 0);
        chk("R1 done", int'(done), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: zero weights -> every sum is zero -> all ones after one round
        do_run("R1 zero weights", 1'b0, 1'b0);
        chk("R1 all ones", int'(state), (1 << N) - 1);

        // R3: pattern write clears done
        write_pat(8'hA5);
        chk("R3 pattern", int'(state), 8'hA5);
        chk("R6 done cleared by pattern", int'(done), 0);

        // R2/R4/R6: random symmetric networks
        for (int t = 0; t < 12; t++) begin
            load_random_weights(12);
            write_pat(N'($urandom()));
            do_run("R2 random", 1'b0, 1'b0);
        end

        // R7: mutual inhibition oscillates between all-zero and all-one
        for (int i = 0; i < N; i++)
            for (int j = 0; j < N; j++) write_w(i, j, (i == j) ? 0 : -5);
        write_pat('0);
        do_run("R7 oscillation", 1'b0, 1'b0);

        // R8: learning from zero weights, then recall of a noisy copy
        for (int i = 0; i < N; i++) for (int j = 0; j < N; j++) write_w(i, j, 0);
        write_pat(8'b1100_1010);
        do_learn("R8 first");
        write_pat(8'b1100_1011);
        do_run("R8 recall", 1'b0, 1'b0);
        chk("R8 stored pattern", int'(state), 8'b1100_1010);

        // R8: saturation after many repetitions, then a different pattern
        write_pat(8'b0110_0011);
        for (int k = 0; k < 40; k++) do_learn("R8 saturate");
        write_pat(8'b1010_0101);
        for (int k = 0; k < 3; k++) do_learn("R8 after sat");
        write_pat(8'b0110_0001);
        do_run("R8 sat recall", 1'b0, 1'b0);

        // R8: diagonal weights are never changed by learning
        for (int i = 0; i < N; i++)
            for (int j = 0; j < N; j++) write_w(i, j, (i == j) ? WLO + 1 : 0);
        write_pat(8'h3C);
        for (int k = 0; k < 2; k++) do_learn("R8 diag");
        write_pat(8'h0F);
        do_run("R8 diag recall", 1'b0, 1'b0);

        // R10/R2/R3: stimulus while busy is ignored
        load_random_weights(10);
        write_pat(N'($urandom()));
        do_run("R10 disturbed", 1'b0, 1'b1);
        write_pat(N'($urandom()));
        do_run("R2 weight write while busy ignored", 1'b0, 1'b0);

        // R9: run and learn together -> only the run
        write_pat(N'($urandom()));
        do_run("R9 run wins", 1'b1, 1'b0);
        write_pat(N'($urandom()));
        do_run("R11 weights kept", 1'b0, 1'b0);

        // a few more random mixes of learning and recall
        for (int t = 0; t < 4; t++) begin
            write_pat(N'($urandom()));
            do_learn("R8 mix");
            write_pat(N'($urandom()));
            do_run("R11 mix", 1'b0, 1'b0);
        end

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule